// File: doc/BRIEF.md
# Six-Mode Programmable Down-Counter

This block is one 16-bit down-counting timer channel. A host writes a control byte that picks one of six waveform behaviours, then writes a starting count as two bytes. After that, each single-cycle pulse on the count-enable input (`tick`) steps the count down by one. Host writes, ticks and the gate input all act inside one synchronous clock domain. The gate line comes from outside and passes through a synchronizer before use. The channel drives one output line whose shape depends on the mode:

- an event counter that raises its line at zero;
- a one-shot that the gate restarts;
- a divide-by-N rate pulse;
- a square wave;
- a strobe triggered by a count write, and a strobe triggered by the gate.

The live count is always visible on a read port, and reading it never pauses counting. A stored count of zero counts as 65536. Counting stays frozen while only the low byte of a new count has been written.

Top module: `sixmode_counter`

## Requirements
- R1: A control write (`wr_ctl`=1) is accepted only when the byte has the form 0011_mmm0 with mmm from 0 to 5. mmm selects the mode (0 event, 1 one-shot, 2 rate, 3 square, 4 write strobe, 5 gate strobe). Acceptance stops counting and sets the output low for mode 0 and high for every other mode. Any other control byte leaves the mode, count and output unchanged.
- R2: A count is written as two data writes (`wr_ctl`=0): the low byte first, then the high byte. The count loads one cycle after the high byte is taken. After only the low byte, ticks do not change the count. A loaded 0 steps to 0xFFFF on the next tick, so it acts as 65536.
- R3: In mode 0, loading makes the output low and starts counting. The output goes high on the tick that reaches 0. Counting then stops and the output stays high until the next load.
- R4: In mode 1, the output stays high after a load and ticks are ignored until a gate rising edge. That edge reloads the count and drives the output low. The output goes high again on the tick that reaches 0. A new gate rising edge reloads the count at any time.
- R5: In mode 2, the output is low exactly while the count equals 1. The tick that leaves 1 reloads the count. While the gate is low, ticks are ignored and the output is held high.
- R6: In mode 3, the count runs from N down to 1 and then reloads. The output is high while the count is above floor(N/2) and low otherwise, so for an odd N the extra tick falls in the high phase. The gate level suspends counting as in R5.
- R7: In mode 4, each load starts one pass: the output is high, goes low while the count is 1, and returns high at 0, where counting stops. Every new count write starts a new pass.
- R8: In mode 5, a pass runs as in R7 but is started by a gate rising edge, which reloads the stored count. A load alone does not start it.
- R9: `count_rd` shows the live count and changes on the clock edge that takes a tick.
- R10: After reset, the count is 0, the output is low, the mode is 0 and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_ctl | input | 1 | 1 = control byte, 0 = count byte |
| wr_data | input | 8 | Host write data |
| tick | input | 1 | Count-enable pulse, one clock wide |
| gate | input | 1 | Asynchronous gate line |
| count_rd | output | 16 | Live count value |
| out_line | output | 1 | Waveform output |

## Verification
There are three latencies:

- **Count write:** the high byte is registered in the host interface and applied one edge later, so a loaded count is visible two edges after the high-byte write.
- **Tick:** a tick changes `count_rd` and `out_line` on the edge that samples it.
- **Gate:** a gate change acts on the third edge after it is driven, because of two synchronizer flops and one edge-detect flop.

The bench drives every input on the falling edge. It waits three falling edges after each write, four after each gate change, and one after each tick before it queues the expected count and output level. Every comparison is therefore made after all of these latencies have elapsed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        MODE_EVENT   = 3'd0,
        MODE_ONESHOT = 3'd1,
        MODE_RATE    = 3'd2,
        MODE_SQUARE  = 3'd3,
        MODE_WSTROBE = 3'd4,
        MODE_GSTROBE = 3'd5
    } mode_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] value;
    } load_req_t;

    // Control byte acceptance: upper nibble 3, bit 0 clear, mode field 0..5.
    function automatic logic ctl_ok(input logic [BYTE_W-1:0] b);
        return (b[7:4] == 4'h3) && !b[0] && (b[3:1] <= 3'd5);
    endfunction

    function automatic mode_e ctl_mode(input logic [BYTE_W-1:0] b);
        return mode_e'(b[3:1]);
    endfunction

    // Count value widened by one bit so that a stored zero reads as 2**CNT_W.
    function automatic logic [CNT_W:0] widen(input logic [CNT_W-1:0] v);
        return {(v == '0), v};
    endfunction
endpackage

// File: rtl/cnt_host_if.sv
module cnt_host_if
    import cnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic              wr_ctl_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output mode_e             mode_o,
    output logic              mode_set_o,
    output load_req_t         load_o,
    output logic              hold_o
);
    mode_e             mode_q;
    logic              set_q;
    logic              pend_q;
    logic [BYTE_W-1:0] lo_q;
    load_req_t         load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_EVENT;
            set_q  <= 1'b0;
            pend_q <= 1'b0;
            lo_q   <= '0;
            load_q <= '0;
        end else begin
            set_q        <= 1'b0;
            load_q.valid <= 1'b0;
            if (wr_en_i) begin
                if (wr_ctl_i) begin
                    if (ctl_ok(wr_data_i)) begin
                        mode_q <= ctl_mode(wr_data_i);
                        set_q  <= 1'b1;
                        pend_q <= 1'b0;
                    end
                end else if (!pend_q) begin
                    lo_q   <= wr_data_i;
                    pend_q <= 1'b1;
                end else begin
                    load_q.value <= {wr_data_i, lo_q};
                    load_q.valid <= 1'b1;
                    pend_q       <= 1'b0;
                end
            end
        end
    end

    assign mode_o     = mode_q;
    assign mode_set_o = set_q;
    assign load_o     = load_q;
    assign hold_o     = pend_q;

    assert_bad_ctl_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_ctl_i && !ctl_ok(wr_data_i)) |=> ($stable(mode_q) && !set_q));

    assert_load_after_data_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wr_ctl_i && pend_q) |=> load_q.valid);
endmodule

// File: rtl/cnt_gate_sync.sv
module cnt_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    output logic level_o,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;
    logic [LEN-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q[0] <= 1'b0;
        else     sh_q[0] <= gate_i;
    end

    for (genvar i = 1; i < LEN; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh_q[i] <= 1'b0;
            else     sh_q[i] <= sh_q[i-1];
        end
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];

    assert_single_rise_R4: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/cnt_engine.sv
module cnt_engine
    import cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_set_i,
    input  mode_e            mode_i,
    input  load_req_t        load_i,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic             gate_lvl_i,
    input  logic             gate_rise_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    mode_e            mode_q;
    logic [CNT_W-1:0] cnt_q, reload_q;
    logic             run_q, armed_q, out_q;

    logic [CNT_W-1:0] nxt;
    logic [CNT_W:0]   half;
    logic             at_one, gated_mode, gate_trig_mode, suspended, step_ok;

    always_comb begin
        nxt            = cnt_q - 1'b1;
        at_one         = (cnt_q == CNT_W'(1));
        half           = widen(reload_q) >> 1;
        gated_mode     = (mode_q == MODE_RATE) || (mode_q == MODE_SQUARE);
        gate_trig_mode = (mode_q == MODE_ONESHOT) || (mode_q == MODE_GSTROBE);
        suspended      = gated_mode && !gate_lvl_i;
        step_ok        = tick_i && run_q && !hold_i && !suspended;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_EVENT;
            cnt_q    <= '0;
            reload_q <= '0;
            run_q    <= 1'b0;
            armed_q  <= 1'b0;
            out_q    <= 1'b0;
        end else if (mode_set_i) begin
            mode_q  <= mode_i;
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= (mode_i != MODE_EVENT);
        end else if (load_i.valid) begin
            reload_q <= load_i.value;
            cnt_q    <= load_i.value;
            armed_q  <= 1'b1;
            case (mode_q)
                MODE_EVENT:                 begin run_q <= 1'b1; out_q <= 1'b0; end
                MODE_ONESHOT, MODE_GSTROBE: begin run_q <= 1'b0; out_q <= 1'b1; end
                default:                    begin run_q <= 1'b1; out_q <= 1'b1; end
            endcase
        end else if (gate_rise_i && armed_q && gate_trig_mode) begin
            cnt_q <= reload_q;
            run_q <= 1'b1;
            out_q <= (mode_q != MODE_ONESHOT);
        end else if (run_q && suspended) begin
            out_q <= 1'b1;
        end else if (step_ok) begin
            case (mode_q)
                MODE_EVENT, MODE_ONESHOT: begin
                    cnt_q <= nxt;
                    if (at_one) begin
                        out_q <= 1'b1;
                        run_q <= 1'b0;
                    end
                end
                MODE_WSTROBE, MODE_GSTROBE: begin
                    cnt_q <= nxt;
                    out_q <= (nxt != CNT_W'(1));
                    if (at_one) run_q <= 1'b0;
                end
                MODE_RATE: begin
                    if (at_one) begin
                        cnt_q <= reload_q;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= nxt;
                        out_q <= (nxt != CNT_W'(1));
                    end
                end
                default: begin
                    if (at_one) begin
                        cnt_q <= reload_q;
                        out_q <= 1'b1;
                    end else begin
                        cnt_q <= nxt;
                        out_q <= (widen(nxt) > half);
                    end
                end
            endcase
        end
    end

    assign count_o = cnt_q;
    assign out_o   = out_q;

    assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !mode_set_i && !load_i.valid && !gate_rise_i) |=> $stable(cnt_q));

    assert_event_out_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EVENT && out_q && !mode_set_i && !load_i.valid) |=> out_q);

    assert_oneshot_trigger_R4: assert property (@(posedge clk) disable iff (rst)
        (gate_rise_i && armed_q && mode_q == MODE_ONESHOT && !mode_set_i && !load_i.valid)
        |=> (!out_q && cnt_q == $past(reload_q)));

    assert_gate_low_suspends_R5: assert property (@(posedge clk) disable iff (rst)
        (run_q && gated_mode && !gate_lvl_i && !mode_set_i && !load_i.valid)
        |=> (out_q && $stable(cnt_q)));

    assert_strobe_one_tick_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WSTROBE && !out_q && step_ok && !mode_set_i && !load_i.valid) |=> out_q);
endmodule

// File: rtl/sixmode_counter.sv
module sixmode_counter
    import cnt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_ctl,
    input  logic [7:0]  wr_data,
    input  logic        tick,
    input  logic        gate,
    output logic [15:0] count_rd,
    output logic        out_line
);
    mode_e     mode;
    logic      mode_set, hold, gate_lvl, gate_rise;
    load_req_t load;

    cnt_host_if u_host (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_ctl_i  (wr_ctl),
        .wr_data_i (wr_data),
        .mode_o    (mode),
        .mode_set_o(mode_set),
        .load_o    (load),
        .hold_o    (hold)
    );

    cnt_gate_sync #(.STAGES(2)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .gate_i (gate),
        .level_o(gate_lvl),
        .rise_o (gate_rise)
    );

    cnt_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .mode_set_i (mode_set),
        .mode_i     (mode),
        .load_i     (load),
        .hold_i     (hold),
        .tick_i     (tick),
        .gate_lvl_i (gate_lvl),
        .gate_rise_i(gate_rise),
        .count_o    (count_rd),
        .out_o      (out_line)
    );
endmodule

// File: tb/sixmode_counter_test.sv
module sixmode_counter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_ctl = 1'b0, tick = 1'b0, gate = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count_rd;
    logic        out_line;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    string       q_tag[$];
    logic [16:0] q_exp[$];
    event        sample_ev;

    always #5 clk = ~clk;

    sixmode_counter uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_data(wr_data),
        .tick(tick), .gate(gate), .count_rd(count_rd), .out_line(out_line)
    );

    // Monitor: pop each expected item and compare against the outputs.
    always begin
        @(sample_ev);
        while (q_exp.size() > 0) begin
            automatic logic [16:0] e = q_exp.pop_front();
            automatic string t = q_tag.pop_front();
            n_checks++;
            if ({count_rd, out_line} !== e) begin
                n_fail++;
                $display("FAIL %s: count=%0d out=%0b expected count=%0d out=%0b",
                         t, count_rd, out_line, e[16:1], e[0]);
            end
        end
    end

    task automatic expect_st(input int c, input bit o, input string t);
        q_exp.push_back({c[15:0], o});
        q_tag.push_back(t);
        -> sample_ev;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input bit ctl, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
    endtask

    task automatic wr_count(input int n);
        wr_byte(1'b0, n[7:0]);
        wr_byte(1'b0, n[15:8]);
    endtask

    task automatic pulse(input int k);
        repeat (k) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_gate(input bit g);
        @(negedge clk); gate = g;
        idle(4);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        expect_st(0, 0, "R10 reset");

        // R3 event counter
        wr_byte(1'b1, 8'h30);
        wr_count(3);
        expect_st(3, 0, "R3 load");
        pulse(1); expect_st(2, 0, "R9 live count");
        pulse(1); expect_st(1, 0, "R3 count 1");
        pulse(1); expect_st(0, 1, "R3 terminal");
        pulse(1); expect_st(0, 1, "R3 stopped at 0");

        // R2 zero means 65536
        wr_count(0);
        expect_st(0, 0, "R2 zero load");
        pulse(1); expect_st(16'hFFFF, 0, "R2 zero wraps");

        // R2 hold between bytes
        wr_count(10);
        pulse(2); expect_st(8, 0, "R2 before hold");
        wr_byte(1'b0, 8'h05);
        pulse(1); expect_st(8, 0, "R2 held after low byte");
        wr_byte(1'b0, 8'h00);
        expect_st(5, 0, "R2 high byte loads");

        // R1 ignored control bytes
        pulse(1); expect_st(4, 0, "R1 counting");
        wr_byte(1'b1, 8'h24);
        pulse(1); expect_st(3, 0, "R1 upper nibble ignored");
        wr_byte(1'b1, 8'h3C);
        pulse(1); expect_st(2, 0, "R1 mode 6 ignored");

        // R1 accepted control halts, sets level
        wr_byte(1'b1, 8'h38);
        expect_st(2, 1, "R1 mode set high");
        pulse(1); expect_st(2, 1, "R1 halted");

        // R7 write-triggered strobe
        wr_count(3);
        expect_st(3, 1, "R7 load");
        pulse(1); expect_st(2, 1, "R7 count 2");
        pulse(1); expect_st(1, 0, "R7 strobe low");
        pulse(1); expect_st(0, 1, "R7 back high");
        pulse(1); expect_st(0, 1, "R7 stopped");
        wr_count(2);
        expect_st(2, 1, "R7 rewrite");
        pulse(1); expect_st(1, 0, "R7 second strobe");
        pulse(1); expect_st(0, 1, "R7 second end");

        // R4 one-shot
        wr_byte(1'b1, 8'h32);
        wr_count(3);
        expect_st(3, 1, "R4 armed");
        pulse(1); expect_st(3, 1, "R4 ticks ignored before gate");
        set_gate(1'b1);
        expect_st(3, 0, "R4 triggered");
        pulse(1); expect_st(2, 0, "R4 counting");
        set_gate(1'b0);
        pulse(1); expect_st(1, 0, "R4 gate fall ignored");
        set_gate(1'b1);
        expect_st(3, 0, "R4 retrigger");
        pulse(3); expect_st(0, 1, "R4 pulse end");

        // R5 rate generator (gate high)
        wr_byte(1'b1, 8'h34);
        wr_count(3);
        expect_st(3, 1, "R5 load");
        pulse(1); expect_st(2, 1, "R5 count 2");
        pulse(1); expect_st(1, 0, "R5 low at 1");
        pulse(1); expect_st(3, 1, "R5 reload");
        pulse(1); expect_st(2, 1, "R5 count 2 again");
        set_gate(1'b0);
        pulse(2); expect_st(2, 1, "R5 gate low suspends");
        set_gate(1'b1);
        pulse(1); expect_st(1, 0, "R5 resumes");

        // R6 square wave, odd then even
        wr_byte(1'b1, 8'h36);
        wr_count(5);
        expect_st(5, 1, "R6 odd load");
        pulse(1); expect_st(4, 1, "R6 odd high");
        pulse(1); expect_st(3, 1, "R6 odd extra high");
        pulse(1); expect_st(2, 0, "R6 odd low");
        pulse(1); expect_st(1, 0, "R6 odd low 2");
        pulse(1); expect_st(5, 1, "R6 odd reload");
        wr_count(4);
        expect_st(4, 1, "R6 even load");
        pulse(1); expect_st(3, 1, "R6 even high");
        pulse(1); expect_st(2, 0, "R6 even low");
        pulse(1); expect_st(1, 0, "R6 even low 2");
        pulse(1); expect_st(4, 1, "R6 even reload");

        // R8 gate-triggered strobe
        wr_byte(1'b1, 8'h3A);
        set_gate(1'b0);
        wr_count(2);
        expect_st(2, 1, "R8 load waits");
        pulse(1); expect_st(2, 1, "R8 no start on load");
        set_gate(1'b1);
        expect_st(2, 1, "R8 triggered");
        pulse(1); expect_st(1, 0, "R8 strobe low");
        pulse(1); expect_st(0, 1, "R8 back high");
        set_gate(1'b0);
        set_gate(1'b1);
        expect_st(2, 1, "R8 retrigger reload");

        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule